// File: doc/BRIEF.md
# Edge-Interval Line Synchronizer

This block locks a receiver onto a bi-phase-mark audio line whose rate is not known in advance. The line arrives already resampled on a fast acquisition clock. A short stability filter removes spurs and an edge detector marks every accepted level change. The block then measures the number of acquisition cycles between consecutive edges. From these intervals it derives two decision thresholds: `th_lo` separates one-unit-interval (UI) gaps from two-UI gaps, and `th_hi` separates two-UI gaps from the three-UI gaps that only occur in preambles.

Acquisition runs in two stages. The first stage is a quick, unaveraged pass that sets rough thresholds from the shortest and longest gaps seen. The second stage decodes a full window using those rough thresholds. It times the first 24 and the first 40 bit cells of that window and replaces the rough thresholds with averaged ones. A bounded number of attempts is made before the block gives up and raises an error. Once locked, the window is re-measured once per frame, so the thresholds follow slow drift in the line rate. A line that goes quiet for too long sends the block back to the start.

Top module: `edge_interval_sync`

## Requirements
- R1: While `enable` is low, and after reset, `synced`, `sync_err`, `th_lo` and `th_hi` are all 0.
- R2: A line level that lasts fewer than FILT_LEN acquisition cycles is not taken as an edge. One-cycle spurs injected into a locked stream leave `synced` at 1 and leave both thresholds unchanged.
- R3: The first edge after `enable` only starts timing. The next COARSE_N intervals are scanned for their minimum and maximum. Then `th_lo` = min + floor(min/4) and `th_hi` = floor((5·min + 2·max)/4), while `synced` stays 0.
- R4: After the rough thresholds are set, a preamble marker must arrive within SEARCH_N intervals, or the attempt fails. A preamble marker is an interval of at least `th_hi` that does not directly follow another such interval.
- R5: Intervals are classed short (below `th_lo`, 1 UI), mid (below `th_hi`, 2 UI) or long (3 UI). Positions are counted from the start of the marker, which ends at UI 3. Each 64-UI subframe has a header (UI 0 to 7) and a data part. The attempt fails in any of these cases:
  - an interval inside a header would run past UI 8 of that subframe;
  - the interval that starts at UI 0 of a subframe is not long;
  - a long interval appears in the data part;
  - a mid interval starts on an odd UI in the data part.
  The check window closes at UI 80.
- R6: Each failed attempt counts once. When the count reaches `max_attempts`, `sync_err` rises, the block stops, and it stays stopped, ignoring the line, until `enable` falls. With the line never showing a marker, exactly `max_attempts` attempts of COARSE_N + SEARCH_N intervals are made.
- R7: When the window passes, let S be the cycle count from UI 0 to UI 48 plus the cycle count from UI 0 to UI 80. Then `th_lo` = floor(3·S/256), `th_hi` = floor(5·S/256), and `synced` rises.
- R8: While `synced` is 1, each following frame's window recomputes both thresholds by R7. A change of a few percent in line rate is followed without `synced` falling.
- R9: If no edge arrives for `timeout_cycles` cycles in any active state, `synced` clears and acquisition restarts from R3. It then relocks at whatever the new rate is.
- R10: `synced` and `sync_err` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs acquisition; low clears all state |
| line_in | input | 1 | Line level, already resampled on `clk` |
| max_attempts | input | ATW | Number of failed attempts before giving up |
| timeout_cycles | input | CW | Edge-free cycles that force a restart |
| th_lo | output | CW | Short/mid decision threshold, in cycles |
| th_hi | output | CW | Mid/long decision threshold, in cycles |
| synced | output | 1 | Averaged thresholds valid and tracking |
| sync_err | output | 1 | Attempt budget exhausted |

## Verification
The assertions assume that the line holds each level for at least FILT_LEN cycles apart from isolated spurs, so that accepted edges are never adjacent. They also assume that `max_attempts` and `timeout_cycles` stay constant while `enable` is high. The stimulus respects both. The generator builds every interval from a whole number of UIs of at least six cycles. Its spurs last a single cycle and sit in the middle of gaps of two UI or more. Both control inputs are changed only while `enable` is low, or while the line is idle and a timeout is being provoked on purpose.

// File: rtl/eis_pkg.sv
package eis_pkg;
    typedef enum logic [2:0] {
        ST_ARM    = 3'd0,
        ST_COARSE = 3'd1,
        ST_SEARCH = 3'd2,
        ST_CHECK  = 3'd3,
        ST_STOP   = 3'd4
    } eis_state_e;

    // value equals the interval length in UI
    typedef enum logic [1:0] {
        IV_NONE  = 2'd0,
        IV_SHORT = 2'd1,
        IV_MID   = 2'd2,
        IV_LONG  = 2'd3
    } iv_class_e;
endpackage

// File: rtl/eis_edge_filter.sv
module eis_edge_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_o
);
    typedef struct packed {
        logic [FILT_LEN-1:0] sh;
        logic                lvl;
        logic                edg;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d     = filt_q;
        filt_d.sh  = {filt_q.sh[FILT_LEN-2:0], line_in};
        filt_d.edg = 1'b0;
        if ((&filt_q.sh) && !filt_q.lvl) begin
            filt_d.lvl = 1'b1;
            filt_d.edg = 1'b1;
        end else if (!(|filt_q.sh) && filt_q.lvl) begin
            filt_d.lvl = 1'b0;
            filt_d.edg = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end

    assign edge_o = filt_q.edg;

    // R2
    edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        filt_q.edg |=> !filt_q.edg);
endmodule

// File: rtl/eis_interval.sv
module eis_interval #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    output logic [CW-1:0] iv_o,
    output logic [CW-1:0] run_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (edge_i)       cnt_d = '0;
        else if (&cnt_q)  cnt_d = cnt_q;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign iv_o  = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    assign run_o = cnt_q;

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !edge_i) |=> (&cnt_q));
endmodule

// File: rtl/eis_classify.sv
module eis_classify
    import eis_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] iv_i,
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    output iv_class_e     cls_o
);
    always_comb begin
        if (iv_i < lo_i)      cls_o = IV_SHORT;
        else if (iv_i < hi_i) cls_o = IV_MID;
        else                  cls_o = IV_LONG;
    end
endmodule

// File: rtl/edge_interval_sync.sv
module edge_interval_sync
    import eis_pkg::*;
#(
    parameter int CW       = 12,
    parameter int ATW      = 4,
    parameter int FILT_LEN = 3,
    parameter int COARSE_N = 70,
    parameter int SEARCH_N = 70
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           line_in,
    input  logic [ATW-1:0] max_attempts,
    input  logic [CW-1:0]  timeout_cycles,
    output logic [CW-1:0]  th_lo,
    output logic [CW-1:0]  th_hi,
    output logic           synced,
    output logic           sync_err
);
    localparam int NMAX = (COARSE_N > SEARCH_N) ? COARSE_N : SEARCH_N;
    localparam int TCW  = $clog2(NMAX + 1);
    localparam int ACW  = CW + 7;
    localparam int FW   = CW + 11;
    localparam logic [6:0] POS_W24 = 7'd48;
    localparam logic [6:0] POS_W40 = 7'd80;

    typedef struct packed {
        eis_state_e     st;
        logic [TCW-1:0] tcnt;
        logic [CW-1:0]  mn;
        logic [CW-1:0]  mx;
        logic [CW-1:0]  lo;
        logic [CW-1:0]  hi;
        logic [6:0]     pos;
        logic [ACW-1:0] acc;
        logic [ACW-1:0] w24;
        logic [ATW-1:0] att;
        logic           plong;
        logic           synced;
        logic           err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          edge_w;
    logic [CW-1:0] iv_w, run_w;
    iv_class_e     cls_w;

    eis_edge_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .edge_o(edge_w));
    eis_interval #(.CW(CW)) u_ival (
        .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .iv_o(iv_w), .run_o(run_w));
    eis_classify #(.CW(CW)) u_cls (
        .iv_i(iv_w), .lo_i(seq_q.lo), .hi_i(seq_q.hi), .cls_o(cls_w));

    function automatic logic [CW-1:0] clip(input logic [FW-1:0] v);
        clip = (|v[FW-1:CW]) ? '1 : v[CW-1:0];
    endfunction

    logic [1:0]     len_w;
    logic [CW-1:0]  mn_n, mx_n;
    logic [FW-1:0]  mn_x, mx_x, s_sum;
    logic [6:0]     n_pos;
    logic [5:0]     ph;
    logic [ACW:0]   acc_w;
    logic [ACW-1:0] acc_n;
    logic [ATW:0]   att_inc;
    logic           bad, fail_ev;

    always_comb begin
        seq_d   = seq_q;
        fail_ev = 1'b0;
        len_w   = cls_w;
        mn_n    = (iv_w < seq_q.mn) ? iv_w : seq_q.mn;
        mx_n    = (iv_w > seq_q.mx) ? iv_w : seq_q.mx;
        mn_x    = {{(FW-CW){1'b0}}, mn_n};
        mx_x    = {{(FW-CW){1'b0}}, mx_n};
        n_pos   = seq_q.pos + {5'd0, len_w};
        ph      = seq_q.pos[5:0];
        acc_w   = {1'b0, seq_q.acc} + {{(ACW+1-CW){1'b0}}, iv_w};
        acc_n   = acc_w[ACW] ? '1 : acc_w[ACW-1:0];
        s_sum   = {{(FW-ACW){1'b0}}, seq_q.w24} + {{(FW-ACW){1'b0}}, acc_n};
        att_inc = {1'b0, seq_q.att} + 1'b1;
        if (ph < 6'd8)
            bad = (ph == 6'd0 && cls_w != IV_LONG) ||
                  (({1'b0, ph} + {5'd0, len_w}) > 7'd8);
        else
            bad = (cls_w == IV_LONG) || (cls_w == IV_MID && ph[0]);

        if (!enable) begin
            seq_d = '0;
        end else if (seq_q.st != ST_ARM && seq_q.st != ST_STOP && !edge_w &&
                     run_w >= timeout_cycles) begin
            seq_d.st     = ST_ARM;
            seq_d.synced = 1'b0;
        end else if (edge_w) begin
            seq_d.plong = (cls_w == IV_LONG);
            unique case (seq_q.st)
                ST_ARM: begin
                    seq_d.st   = ST_COARSE;
                    seq_d.tcnt = '0;
                    seq_d.mn   = '1;
                    seq_d.mx   = '0;
                end
                ST_COARSE: begin
                    seq_d.mn = mn_n;
                    seq_d.mx = mx_n;
                    if (seq_q.tcnt == TCW'(COARSE_N - 1)) begin
                        seq_d.lo    = clip(mn_x + (mn_x >> 2));
                        seq_d.hi    = clip(((mn_x << 2) + mn_x + (mx_x << 1)) >> 2);
                        seq_d.st    = ST_SEARCH;
                        seq_d.tcnt  = '0;
                        seq_d.plong = 1'b1;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
                ST_SEARCH: begin
                    if (cls_w == IV_LONG && !seq_q.plong) begin
                        seq_d.st  = ST_CHECK;
                        seq_d.pos = 7'd3;
                        seq_d.acc = {{(ACW-CW){1'b0}}, iv_w};
                    end else if (seq_q.tcnt == TCW'(SEARCH_N - 1)) begin
                        fail_ev = 1'b1;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    if (bad) begin
                        fail_ev = 1'b1;
                    end else begin
                        seq_d.pos = n_pos;
                        seq_d.acc = acc_n;
                        if (n_pos == POS_W24) seq_d.w24 = acc_n;
                        if (n_pos == POS_W40) begin
                            seq_d.lo     = clip(((s_sum << 1) + s_sum) >> 8);
                            seq_d.hi     = clip(((s_sum << 2) + s_sum) >> 8);
                            seq_d.synced = 1'b1;
                            seq_d.att    = '0;
                            seq_d.st     = ST_SEARCH;
                            seq_d.tcnt   = '0;
                        end
                    end
                end
                default: ;
            endcase
            if (fail_ev) begin
                seq_d.tcnt = '0;
                seq_d.mn   = '1;
                seq_d.mx   = '0;
                if (seq_q.synced) begin
                    seq_d.synced = 1'b0;
                    seq_d.st     = ST_COARSE;
                end else if (att_inc >= {1'b0, max_attempts}) begin
                    seq_d.att = att_inc[ATW-1:0];
                    seq_d.err = 1'b1;
                    seq_d.st  = ST_STOP;
                end else begin
                    seq_d.att = att_inc[ATW-1:0];
                    seq_d.st  = ST_COARSE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign th_lo    = seq_q.lo;
    assign th_hi    = seq_q.hi;
    assign synced   = seq_q.synced;
    assign sync_err = seq_q.err;

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(synced && sync_err));
    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && enable) |=> sync_err);
    // R6
    stop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_STOP) |-> sync_err);
    // R1
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!synced && !sync_err && th_lo == '0 && th_hi == '0));
    // R7
    th_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synced |-> (th_lo < th_hi));
endmodule

// File: tb/edge_interval_sync_tb.sv
module edge_interval_sync_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 12;
    localparam int ATW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic line = 1'b0;
    logic [ATW-1:0] max_att = 4'd3;
    logic [CW-1:0]  tmo = 12'd200;
    logic [CW-1:0]  th_lo, th_hi;
    logic synced, sync_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ui_cyc = 8;
    int gmode  = 1;   // 0 idle, 1 framed stream, 2 square wave, 3 broken frames
    bit glitch_on = 1'b0;
    int drops = 0;
    logic prev_s = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_interval_sync u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .line_in(line),
        .max_attempts(max_att), .timeout_cycles(tmo),
        .th_lo(th_lo), .th_hi(th_hi), .synced(synced), .sync_err(sync_err));

    always @(negedge clk) begin
        cycles++;
        if (prev_s && !synced) drops++;
        prev_s = synced;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // which: 0 th_lo nonzero, 1 synced, 2 sync_err
    task automatic wait_sig(input int which, input int limit, output int waited);
        waited = 0;
        while (waited < limit) begin
            @(negedge clk);
            waited++;
            if (which == 0 && th_lo != 0) break;
            if (which == 1 && synced) break;
            if (which == 2 && sync_err) break;
        end
    endtask

    task automatic emit(input int nui);
        line = ~line;
        if (glitch_on && nui >= 2) begin
            int h = nui * ui_cyc / 2;
            wait_cyc(h);
            line = ~line;
            wait_cyc(1);
            line = ~line;
            wait_cyc(nui * ui_cyc - h - 1);
        end else begin
            wait_cyc(nui * ui_cyc);
        end
    endtask

    task automatic send_bit(input bit b);
        if (b) begin emit(1); emit(1); end
        else emit(2);
    endtask

    task automatic send_sub(input int frame, input int sub);
        bit par = 1'b0;
        if (sub == 1)        begin emit(3); emit(2); emit(1); emit(2); end
        else if (frame == 0) begin emit(3); emit(1); emit(1); emit(3); end
        else                 begin emit(3); emit(3); emit(1); emit(1); end
        for (int i = 4; i < 31; i++) begin
            bit b = ((i * 5 + frame * 3 + sub) % 7) < 3;
            par ^= b;
            send_bit(b);
        end
        send_bit(par);
    endtask

    initial begin : gen
        int frame = 0;
        int sub = 0;
        forever begin
            case (gmode)
                0: wait_cyc(1);
                2: emit(1);
                3: begin
                    emit(3); emit(1); emit(1);
                    repeat (10) emit(2);
                end
                default: begin
                    send_sub(frame, sub);
                    if (sub == 1) frame = (frame + 1) % 192;
                    sub ^= 1;
                end
            endcase
        end
    end

    task automatic t_reset;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(20);
        chk("R1 synced idle", synced, 0);
        chk("R1 sync_err idle", sync_err, 0);
        chk("R1 th_lo idle", th_lo, 0);
        chk("R1 th_hi idle", th_hi, 0);
    endtask

    task automatic t_lock;
        int w;
        enable = 1'b1;
        wait_sig(0, 20000, w);
        chk("R3 coarse th_lo", th_lo, 10);
        chk("R3 coarse th_hi", th_hi, 22);
        chk("R3 not yet synced", synced, 0);
        wait_sig(1, 20000, w);
        chk("R7 synced", synced, 1);
        chk("R7 fine th_lo", th_lo, 12);
        chk("R7 fine th_hi", th_hi, 20);
        chk("R10 no error when locked", sync_err, 0);
    endtask

    task automatic t_glitch;
        drops = 0;
        glitch_on = 1'b1;
        wait_cyc(4000);
        glitch_on = 1'b0;
        chk("R2 spur keeps lock", synced, 1);
        chk("R2 no lock drop", drops, 0);
        chk("R2 th_lo unchanged", th_lo, 12);
        chk("R2 th_hi unchanged", th_hi, 20);
    endtask

    task automatic t_rate;
        drops = 0;
        ui_cyc = 9;
        wait_cyc(6000);
        chk("R8 still synced", synced, 1);
        chk("R8 no lock drop", drops, 0);
        chk("R8 th_lo tracks", th_lo, 13);
        chk("R8 th_hi tracks", th_hi, 22);
    endtask

    task automatic t_timeout;
        int w;
        gmode = 0;
        wait_cyc(1000);
        chk("R9 timeout clears synced", synced, 0);
        chk("R10 timeout no error", sync_err, 0);
        ui_cyc = 6;
        gmode = 1;
        wait_sig(1, 20000, w);
        chk("R9 relock", synced, 1);
        chk("R9 relock th_lo", th_lo, 9);
        chk("R9 relock th_hi", th_hi, 15);
    endtask

    task automatic t_no_preamble;
        int w;
        enable = 1'b0;
        wait_cyc(3);
        chk("R1 disable clears synced", synced, 0);
        chk("R1 disable clears th_lo", th_lo, 0);
        ui_cyc = 8;
        gmode = 2;
        max_att = 4'd3;
        wait_cyc(600);
        enable = 1'b1;
        wait_sig(2, 20000, w);
        chk("R4 no marker gives error", sync_err, 1);
        chk("R10 error not synced", synced, 0);
        chk("R6 three attempts in window", (w >= 3340 && w <= 3400) ? 1 : 0, 1);
        if (!(w >= 3340 && w <= 3400)) $display("  R6 elapsed=%0d cycles", w);
        gmode = 1;
        wait_cyc(3000);
        chk("R6 stays stopped", sync_err, 1);
        chk("R6 no lock after stop", synced, 0);
        enable = 1'b0;
        wait_cyc(3);
        chk("R6 enable low clears error", sync_err, 0);
    endtask

    task automatic t_bad_frame;
        int w;
        gmode = 3;
        max_att = 4'd1;
        wait_cyc(600);
        enable = 1'b1;
        wait_sig(2, 20000, w);
        chk("R5 broken frame fails", sync_err, 1);
        chk("R5 never synced", synced, 0);
        chk("R10 exclusive flags", (synced && sync_err) ? 1 : 0, 0);
    endtask

    initial begin : watchdog
        wait (cycles > 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_lock();
        t_glitch();
        t_rate();
        t_timeout();
        t_no_preamble();
        t_bad_frame();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule